// File: doc/BRIEF.md
# Excess-3 Decimal Ripple Adder

This block adds two unsigned decimal numbers of `DIGITS` digits each, plus a one-bit decimal carry-in, and returns their sum in the same excess-3 form together with a decimal carry-out. In excess-3, each decimal digit occupies one nibble and holds the digit value plus three. The block is purely combinational and has no clock or reset. Its operands can come straight from registers in the surrounding datapath, and the sum can be registered wherever timing calls for it.

Each digit is handled by its own slice, and the slices are chained by their carries from the least significant digit upward. A slice adds the two coded nibbles and the incoming carry as plain 4-bit binary numbers. The two biases of three together contribute six. Because of that, the binary carry of this first add is set exactly when the true digit sum reaches ten, and that carry becomes the slice's decimal carry. A second 4-bit add then corrects the nibble. When the carry is clear, it takes three away. When the carry is set, it adds three, which wraps the digit around modulo ten. The carry of this correction add is dropped.

Top module: `xs3_decimal_adder`

## Requirements
- R1: A decimal digit d (0..9) is held as the 4-bit code d+3, so 0 is 0011 and 9 is 1100. Operands and sum are packed as 4*DIGITS-bit vectors, with digit 0 in bits [3:0] and digit k in bits [4k+3:4k].
- R2: For valid codes, each output nibble is the excess-3 code of (a_k + b_k + c_k) mod 10, where c_k is the carry into digit k. The output is always a valid code.
- R3: The carry out of digit k is 1 exactly when a_k + b_k + c_k is 10 or more.
- R4: The carry into digit 0 is `cin_i`. The carry into digit k+1 is the carry out of digit k. `cout_o` is the carry out of the most significant digit.
- R5: Digit codes 0100 and 1000 with no carry-in give 1001 and no carry. For example, with DIGITS=4, 16'h3334 + 16'h3338 gives 16'h3339 with `cout_o`=0.
- R6: Digit codes 0111 and 1011 give 0101 and pass a carry on. With DIGITS=4, 16'h3337 + 16'h333B gives 16'h3345 with `cout_o`=0.
- R7: With all digits equal to 9 in both operands and `cin_i`=1, every output digit is 9 (16'hCCCC for DIGITS=4) and `cout_o`=1.
- R8: Adding an operand of all zero codes (0011 in every digit) with `cin_i`=0 returns the other operand unchanged, with `cout_o`=0.
- R9: Across the whole word, the decoded sum equals (A + B + cin) mod 10^DIGITS, and `cout_o` is 1 exactly when A + B + cin is at least 10^DIGITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_xs3_i | input | 4*DIGITS | First operand, excess-3 digits, digit 0 in the low nibble |
| b_xs3_i | input | 4*DIGITS | Second operand, excess-3 digits |
| cin_i | input | 1 | Decimal carry into digit 0 |
| sum_xs3_o | output | 4*DIGITS | Sum in excess-3 digits |
| cout_o | output | 1 | Decimal carry out of the top digit |

## Verification
Zero and one operands show whether the minus-three correction is applied correctly when nothing overflows. Digit sums of exactly nine and exactly ten sit on either side of the carry threshold, so they separate the two correction paths. Long ripples, such as 999+1 and 9999+1 into overflow, and the all-nines case with carry-in show whether the carries chain properly through every slice. A few hundred random valid operands, checked against a decimal reference, catch wrong digit positions and corrections that are wrong only for particular values.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned XS3_BIAS = 3;
  localparam int unsigned XS3_MIN  = XS3_BIAS;
  localparam int unsigned XS3_MAX  = XS3_BIAS + 9;

  typedef logic [NIB_W-1:0] xs3_code_t;

  // Constant added in the correction stage (two's complement of 3 is 1101)
  localparam xs3_code_t ADJ_UP   = xs3_code_t'(XS3_BIAS);
  localparam xs3_code_t ADJ_DOWN = xs3_code_t'(16 - XS3_BIAS);

  function automatic logic code_ok(input xs3_code_t c);
    return (int'(c) >= int'(XS3_MIN)) && (int'(c) <= int'(XS3_MAX));
  endfunction

  function automatic int unsigned code_val(input xs3_code_t c);
    return int'(c) - int'(XS3_BIAS);
  endfunction
endpackage

// File: rtl/xs3_nibble_adder.sv
module xs3_nibble_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = c_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign s_o[i]     = x_i[i] ^ y_i[i] ^ carry[i];
    assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
  end

  assign c_o = carry[WIDTH];
endmodule

// File: rtl/xs3_digit_slice.sv
module xs3_digit_slice
  import xs3_pkg::*;
(
  input  xs3_code_t a_i,
  input  xs3_code_t b_i,
  input  logic      c_i,
  output xs3_code_t s_o,
  output logic      c_o
);
  xs3_code_t raw_sum;
  logic      raw_carry;
  xs3_code_t adj;
  logic      adj_carry_unused;

  // Stage 1: plain binary add of two biased codes (bias 6 total)
  xs3_nibble_adder #(.WIDTH(NIB_W)) u_bin_add (
    .x_i(a_i), .y_i(b_i), .c_i(c_i), .s_o(raw_sum), .c_o(raw_carry)
  );

  // Stage 2: re-bias to excess-3; carry of this stage is not used
  assign adj = raw_carry ? ADJ_UP : ADJ_DOWN;

  xs3_nibble_adder #(.WIDTH(NIB_W)) u_fix_add (
    .x_i(raw_sum), .y_i(adj), .c_i(1'b0), .s_o(s_o), .c_o(adj_carry_unused)
  );

  assign c_o = raw_carry;

  always_comb begin
    if (code_ok(a_i) && code_ok(b_i)) begin
      p_code_valid_r2: assert (code_ok(s_o))
        else $error("slice produced invalid code %b", s_o);
      p_digit_value_r2: assert (code_val(s_o) ==
                                (code_val(a_i) + code_val(b_i) + 32'(c_i)) % 10)
        else $error("slice digit value wrong");
      p_carry_thresh_r3: assert (c_o ==
                                 ((code_val(a_i) + code_val(b_i) + 32'(c_i)) >= 10))
        else $error("slice carry wrong");
    end
    if (a_i == 4'b0100 && b_i == 4'b1000 && !c_i) begin
      p_one_five_r5: assert (s_o == 4'b1001 && !c_o)
        else $error("1+5 case wrong");
    end
    if (a_i == 4'b0111 && b_i == 4'b1011 && !c_i) begin
      p_four_eight_r6: assert (s_o == 4'b0101 && c_o)
        else $error("4+8 case wrong");
    end
  end
endmodule

// File: rtl/xs3_decimal_adder.sv
module xs3_decimal_adder
  import xs3_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [NIB_W*DIGITS-1:0] a_xs3_i,
  input  logic [NIB_W*DIGITS-1:0] b_xs3_i,
  input  logic                    cin_i,
  output logic [NIB_W*DIGITS-1:0] sum_xs3_o,
  output logic                    cout_o
);
  localparam int unsigned VEC_W = NIB_W * DIGITS;
  localparam logic [VEC_W-1:0] ZERO_WORD = {DIGITS{xs3_code_t'(XS3_BIAS)}};

  logic [DIGITS:0] dcarry;
  assign dcarry[0] = cin_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    xs3_digit_slice u_slice (
      .a_i(a_xs3_i[NIB_W*k +: NIB_W]),
      .b_i(b_xs3_i[NIB_W*k +: NIB_W]),
      .c_i(dcarry[k]),
      .s_o(sum_xs3_o[NIB_W*k +: NIB_W]),
      .c_o(dcarry[k+1])
    );
  end

  assign cout_o = dcarry[DIGITS];

  function automatic logic word_ok(input logic [VEC_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < int'(DIGITS); k++) ok &= code_ok(w[NIB_W*k +: NIB_W]);
    return ok;
  endfunction

  always_comb begin
    if (b_xs3_i == ZERO_WORD && !cin_i && word_ok(a_xs3_i)) begin
      p_zero_identity_r8: assert (sum_xs3_o == a_xs3_i && !cout_o)
        else $error("adding zero changed operand");
    end
    if (a_xs3_i == ZERO_WORD && b_xs3_i == ZERO_WORD) begin
      p_carry_passthru_r4: assert (cout_o == 1'b0)
        else $error("carry out with zero operands");
    end
  end
endmodule

// File: tb/xs3_decimal_adder_tb.sv
module xs3_decimal_adder_tb;
  localparam int unsigned D = 4;
  localparam int unsigned W = 4 * D;
  localparam int unsigned LIMIT = 10000;
  localparam int unsigned NV = 11;

  localparam int unsigned VA [NV] = '{0, 1, 0, 4, 5, 9, 999, 9999, 1234, 5555, 0};
  localparam int unsigned VB [NV] = '{0, 0, 1, 5, 5, 1, 1,   1,    8765, 4444, 9999};
  localparam int unsigned VC [NV] = '{0, 0, 0, 0, 0, 0, 0,   0,    1,    0,    1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic cin, cout;
  int tests = 0, fails = 0;
  bit done = 0;

  xs3_decimal_adder #(.DIGITS(D)) u_dut (
    .a_xs3_i(a), .b_xs3_i(b), .cin_i(cin), .sum_xs3_o(s), .cout_o(cout)
  );

  function automatic logic [W-1:0] enc(input int unsigned v);
    logic [W-1:0] r;
    int unsigned t;
    t = v;
    for (int k = 0; k < int'(D); k++) begin
      r[4*k +: 4] = 4'((t % 10) + 3);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp_s, input logic exp_c);
    tests++;
    if (s !== exp_s || cout !== exp_c) begin
      fails++;
      $display("FAIL %s: got sum=%h cout=%b, expected sum=%h cout=%b",
               req, s, cout, exp_s, exp_c);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic dec_case(input string req, input int unsigned x,
                          input int unsigned y, input int unsigned c);
    int unsigned tot;
    tot = x + y + c;
    apply(enc(x), enc(y), c[0]);
    check(req, enc(tot % LIMIT), tot >= LIMIT);
  endtask

  initial begin
    a = enc(0); b = enc(0); cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero codes in, zero codes out
    check("R1 reset/zero", 16'h3333, 1'b0);

    // Table walk: R2, R3, R4, R9 (boundaries 9/10, ripple, overflow)
    for (int i = 0; i < int'(NV); i++) dec_case("R9 table", VA[i], VB[i], VC[i]);

    // R5 literal codes
    apply(16'h3334, 16'h3338, 1'b0);
    check("R5 1+5", 16'h3339, 1'b0);
    // R6 literal codes, carry into digit 1
    apply(16'h3337, 16'h333B, 1'b0);
    check("R6 4+8", 16'h3345, 1'b0);
    // R7 all nines with carry-in
    apply(16'hCCCC, 16'hCCCC, 1'b1);
    check("R7 9999+9999+1", 16'hCCCC, 1'b1);
    // R8 adding zero
    apply(enc(8273), enc(0), 1'b0);
    check("R8 identity", enc(8273), 1'b0);
    // R4 carry-in alone ripples through all nines
    apply(enc(9999), enc(0), 1'b1);
    check("R4 cin ripple", enc(0), 1'b1);
    // R3 digit sum of exactly 10 in a middle digit
    dec_case("R3 threshold", 50, 50, 0);
    dec_case("R2 digit 9 no carry", 4040, 5050, 0);

    // R9 random valid operands
    for (int i = 0; i < 300; i++)
      dec_case("R9 random", $urandom_range(LIMIT-1), $urandom_range(LIMIT-1),
               $urandom_range(1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule